// File: doc/BRIEF.md
# Firmware Glue Register Block

This block is a small memory-mapped peripheral for boot firmware. Behind a 32-byte register window on a simple bus it offers several services. A write can stop the system with an exit code. Reads report which processor is asking and how many processors are present. One level-sensitive interrupt line per processor is set with a combined port/level store. A one-character console input buffer and a one-character console output buffer each carry a status byte.

The bus carries an address, a byte count, write data, a read strobe, a write strobe and the ID of the requesting master. Read data appears in the cycle after the read strobe and stays until the next read. The ID of the master that asked is returned with it. The host-side console streams are ready/valid ports. The output port holds each character until the host accepts it.

Top module: `fw_glue_regs`

## Requirements
- R1: Only address bits [4:0] are decoded, so every register also answers at its offset plus any multiple of 32 (for example 0x28 acts as 0x08 and 0x2A acts as 0x0A).
- R2: A write to offset 0x00 raises `halt_pulse` for exactly one cycle, in the cycle after the write. From that cycle on, `exit_code` holds write byte 0 (`bus_wdata[7:0]`).
- R3: A read of offset 0x04 returns the requesting master ID `bus_mid`, zero-extended. Every read returns the requester's ID on `bus_rid` together with the data.
- R4: A read of offset 0x0A returns the processor count NUM_CPUS.
- R5: A write to offset 0x08 takes byte 0 as the port number and byte 1 as the level, and the level is taken as 0 when `bus_len` is 1. Interrupt line N (`irq_lines[N]`) follows the last level written to port N: a nonzero level drives it to 1 and zero drives it to 0. A port number of NUM_CPUS or more changes no line.
- R6: Read data appears on `bus_rdata` in the cycle after `bus_rd` and holds until the next read. Bits [31:8] are always zero, and a read of any offset other than 0x04, 0x0A, 0x10, 0x14, 0x18 or 0x1A returns 0.
- R7: After reset, output status reads 1 and output data reads 0. Input status and input data read 0. All interrupt lines, `halt_pulse` and `cout_valid` are 0, and `cin_ready` is 1.
- R8: A write to output data (0x18) while the reported output status is nonzero does three things. It raises `cout_valid` in the next cycle with `cout_data` equal to byte 0, held until `cout_ready` is seen high. It stores the byte for read-back at 0x18. It sets output status to 1.
- R9: Output status (0x1A) reads 0 while `cout_ready` is low or a character is still waiting to be accepted. A write to output data in that state is ignored: `cout_valid`, `cout_data` and the 0x18 read-back keep their values.
- R10: `cin_ready` is high only while input status is 0. A character presented with `cin_valid` at that time is captured into input data, and input status becomes 1. Input presented while input status is nonzero is not taken.
- R11: A read of input data (0x10) returns the buffered character and clears input status to 0.
- R12: A write of byte 0 to input data (0x10), input status (0x14) or output status (0x1A) stores that byte directly, and later reads of the same offset return it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; only bits [4:0] are decoded |
| bus_len | input | 3 | Access width in bytes (1, 2 or 4) |
| bus_wdata | input | 32 | Write data, byte 0 in bits [7:0] |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_mid | input | MID_W | ID of the requesting master |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| bus_rid | output | MID_W | Master ID that goes with `bus_rdata` |
| halt_pulse | output | 1 | One-cycle stop request |
| exit_code | output | 8 | Last exit code written |
| irq_lines | output | NUM_CPUS | Level-sensitive interrupt line per processor |
| cin_valid | input | 1 | Console input character valid |
| cin_data | input | 8 | Console input character |
| cin_ready | output | 1 | Input buffer can take a character |
| cout_valid | output | 1 | Console output character valid |
| cout_data | output | 8 | Console output character |
| cout_ready | input | 1 | Host accepts the output character |

## Verification
The bench builds the block with NUM_CPUS=3, MID_W=2 and ADDR_W=8. A count of three is not a power of two, so port number 3 fits in the port byte and is still out of range. This exercises the ignored-port case next to a real highest port, line 2. Eight address bits reach the aliased copies at 0x28, 0x2A and 0xE0. Two ID bits let the processor index read return values other than zero.

// File: rtl/fwg_pkg.sv
package fwg_pkg;

    localparam int OFF_W = 5;

    localparam logic [OFF_W-1:0] OFF_EXIT      = 5'h00;
    localparam logic [OFF_W-1:0] OFF_CPUID     = 5'h04;
    localparam logic [OFF_W-1:0] OFF_IRQ       = 5'h08;
    localparam logic [OFF_W-1:0] OFF_NCPU      = 5'h0A;
    localparam logic [OFF_W-1:0] OFF_CIN_DATA  = 5'h10;
    localparam logic [OFF_W-1:0] OFF_CIN_STAT  = 5'h14;
    localparam logic [OFF_W-1:0] OFF_COUT_DATA = 5'h18;
    localparam logic [OFF_W-1:0] OFF_COUT_STAT = 5'h1A;

    typedef struct packed {
        logic exit_r;
        logic cpuid;
        logic irq;
        logic ncpu;
        logic cin_data;
        logic cin_stat;
        logic cout_data;
        logic cout_stat;
    } fwg_hit_t;

    typedef struct packed {
        logic [7:0] in_data;
        logic [7:0] in_stat;
        logic [7:0] out_data;
        logic [7:0] out_stat;
        logic       pend;
    } fwg_con_t;

endpackage

// File: rtl/fwg_decode.sv
module fwg_decode
    import fwg_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output fwg_hit_t          hit
);

    logic [OFF_W-1:0] off;
    logic             unused_hi;

    assign off       = addr[OFF_W-1:0];
    assign unused_hi = ^addr[ADDR_W-1:OFF_W];

    always_comb begin
        hit           = '0;
        hit.exit_r    = (off == OFF_EXIT);
        hit.cpuid     = (off == OFF_CPUID);
        hit.irq       = (off == OFF_IRQ);
        hit.ncpu      = (off == OFF_NCPU);
        hit.cin_data  = (off == OFF_CIN_DATA);
        hit.cin_stat  = (off == OFF_CIN_STAT);
        hit.cout_data = (off == OFF_COUT_DATA);
        hit.cout_stat = (off == OFF_COUT_STAT);
    end

endmodule

// File: rtl/fwg_irq.sv
module fwg_irq #(
    parameter int NUM_CPUS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [7:0]          port,
    input  logic [7:0]          level,
    output logic [NUM_CPUS-1:0] irq_o
);

    logic [NUM_CPUS-1:0] lines_d;
    logic [NUM_CPUS-1:0] lines_q;

    for (genvar i = 0; i < NUM_CPUS; i++) begin : g_line
        always_comb begin
            lines_d[i] = lines_q[i];
            if (wr_en && (port == 8'(i))) begin
                lines_d[i] = (level != 8'd0);
            end
        end

        // R5: a write addressed to this port sets the line to the level's truth
        assert_irq_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (port == 8'(i))) |=> (irq_o[i] == ($past(level) != 8'd0)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lines_q <= '0;
        end else begin
            lines_q <= lines_d;
        end
    end

    assign irq_o = lines_q;

    // R5: without a write to the interrupt register every line holds
    assert_irq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(irq_o));

endmodule

// File: rtl/fwg_console.sv
module fwg_console
    import fwg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  fwg_hit_t   hit,
    input  logic       rd,
    input  logic       wr,
    input  logic [7:0] wbyte,
    input  logic       cin_valid,
    input  logic [7:0] cin_data,
    output logic       cin_ready,
    output logic       cout_valid,
    output logic [7:0] cout_data,
    input  logic       cout_ready,
    output logic [7:0] in_data_o,
    output logic [7:0] in_stat_o,
    output logic [7:0] out_data_o,
    output logic [7:0] out_stat_o
);

    fwg_con_t s_d;
    fwg_con_t s_q;
    logic     out_open;
    logic     sw_in_touch;

    assign out_open    = !s_q.pend && cout_ready;
    assign sw_in_touch = (wr && (hit.cin_data || hit.cin_stat)) || (rd && hit.cin_data);
    assign cin_ready   = (s_q.in_stat == 8'd0) && !sw_in_touch;

    always_comb begin
        s_d = s_q;
        if (s_q.pend && cout_ready) begin
            s_d.pend = 1'b0;
        end
        if (cin_valid && cin_ready) begin
            s_d.in_data = cin_data;
            s_d.in_stat = 8'd1;
        end
        if (rd && hit.cin_data) begin
            s_d.in_stat = 8'd0;
        end
        if (wr) begin
            if (hit.cin_data) begin
                s_d.in_data = wbyte;
            end
            if (hit.cin_stat) begin
                s_d.in_stat = wbyte;
            end
            if (hit.cout_stat) begin
                s_d.out_stat = wbyte;
            end
            if (hit.cout_data && out_open && (s_q.out_stat != 8'd0)) begin
                s_d.out_data = wbyte;
                s_d.out_stat = 8'd1;
                s_d.pend     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.out_stat <= 8'd1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cout_valid = s_q.pend;
    assign cout_data  = s_q.out_data;
    assign in_data_o  = s_q.in_data;
    assign in_stat_o  = s_q.in_stat;
    assign out_data_o = s_q.out_data;
    assign out_stat_o = out_open ? s_q.out_stat : 8'd0;

    // R8: a waiting character is held steady until the host takes it
    assert_cout_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cout_valid && !cout_ready) |=> (cout_valid && $stable(cout_data)));

    // R9: a write to output data while the port is closed leaves the data alone
    assert_cout_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit.cout_data && (!cout_ready || cout_valid)) |=> $stable(cout_data));

    // R10: a handshake on the input port fills the buffer
    assert_cin_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cin_valid && cin_ready) |=> ((in_stat_o == 8'd1) && (in_data_o == $past(cin_data))));

    // R11: reading input data empties the buffer
    assert_cin_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && hit.cin_data && !wr) |=> (in_stat_o == 8'd0));

endmodule

// File: rtl/fw_glue_regs.sv
module fw_glue_regs
    import fwg_pkg::*;
#(
    parameter int NUM_CPUS = 4,
    parameter int MID_W    = 2,
    parameter int ADDR_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [2:0]          bus_len,
    input  logic [31:0]         bus_wdata,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [MID_W-1:0]    bus_mid,
    output logic [31:0]         bus_rdata,
    output logic [MID_W-1:0]    bus_rid,
    output logic                halt_pulse,
    output logic [7:0]          exit_code,
    output logic [NUM_CPUS-1:0] irq_lines,
    input  logic                cin_valid,
    input  logic [7:0]          cin_data,
    output logic                cin_ready,
    output logic                cout_valid,
    output logic [7:0]          cout_data,
    input  logic                cout_ready
);

    localparam logic [7:0] CPU_COUNT = 8'(NUM_CPUS);

    typedef struct packed {
        logic             halt;
        logic [7:0]       exit_code;
        logic [7:0]       rdata;
        logic [MID_W-1:0] rid;
    } top_t;

    fwg_hit_t   hit;
    top_t       s_d;
    top_t       s_q;
    logic [7:0] irq_level;
    logic [7:0] rd_byte;
    logic [7:0] in_data_v;
    logic [7:0] in_stat_v;
    logic [7:0] out_data_v;
    logic [7:0] out_stat_v;
    logic       unused_wdata;

    assign unused_wdata = ^bus_wdata[31:16];

    fwg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .hit  (hit)
    );

    assign irq_level = (bus_len > 3'd1) ? bus_wdata[15:8] : 8'd0;

    fwg_irq #(.NUM_CPUS(NUM_CPUS)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr && hit.irq),
        .port  (bus_wdata[7:0]),
        .level (irq_level),
        .irq_o (irq_lines)
    );

    fwg_console u_con (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .rd         (bus_rd),
        .wr         (bus_wr),
        .wbyte      (bus_wdata[7:0]),
        .cin_valid  (cin_valid),
        .cin_data   (cin_data),
        .cin_ready  (cin_ready),
        .cout_valid (cout_valid),
        .cout_data  (cout_data),
        .cout_ready (cout_ready),
        .in_data_o  (in_data_v),
        .in_stat_o  (in_stat_v),
        .out_data_o (out_data_v),
        .out_stat_o (out_stat_v)
    );

    always_comb begin
        unique case (1'b1)
            hit.cpuid:     rd_byte = 8'(bus_mid);
            hit.ncpu:      rd_byte = CPU_COUNT;
            hit.cin_data:  rd_byte = in_data_v;
            hit.cin_stat:  rd_byte = in_stat_v;
            hit.cout_data: rd_byte = out_data_v;
            hit.cout_stat: rd_byte = out_stat_v;
            default:       rd_byte = 8'd0;
        endcase
    end

    always_comb begin
        s_d      = s_q;
        s_d.halt = bus_wr && hit.exit_r;
        if (bus_wr && hit.exit_r) begin
            s_d.exit_code = bus_wdata[7:0];
        end
        if (bus_rd) begin
            s_d.rdata = rd_byte;
            s_d.rid   = bus_mid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata  = {24'd0, s_q.rdata};
    assign bus_rid    = s_q.rid;
    assign halt_pulse = s_q.halt;
    assign exit_code  = s_q.exit_code;

    // R2: exit write gives a halt pulse carrying byte 0
    assert_exit_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit.exit_r) |=> (halt_pulse && (exit_code == $past(bus_wdata[7:0]))));

    // R2: no pulse without an exit write
    assert_no_halt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && hit.exit_r) |=> !halt_pulse);

    // R3: read response carries the requester's ID
    assert_rid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> (bus_rid == $past(bus_mid)));

    // R4: count read returns the processor count
    assert_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit.ncpu) |=> (bus_rdata == 32'(NUM_CPUS)));

    // R6: unmapped reads return zero
    assert_unmapped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (hit == '0)) |=> (bus_rdata == 32'd0));

    // R6: read data holds between reads
    assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/sim_fw_glue_regs.sv
module sim_fw_glue_regs;

    localparam int NC = 3;
    localparam int MW = 2;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [2:0]    bus_len = 3'd1;
    logic [31:0]   bus_wdata = '0;
    logic          bus_rd = 1'b0;
    logic          bus_wr = 1'b0;
    logic [MW-1:0] bus_mid = '0;
    logic [31:0]   bus_rdata;
    logic [MW-1:0] bus_rid;
    logic          halt_pulse;
    logic [7:0]    exit_code;
    logic [NC-1:0] irq_lines;
    logic          cin_valid = 1'b0;
    logic [7:0]    cin_data = '0;
    logic          cin_ready;
    logic          cout_valid;
    logic [7:0]    cout_data;
    logic          cout_ready = 1'b1;

    fw_glue_regs #(.NUM_CPUS(NC), .MID_W(MW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_len(bus_len),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_mid(bus_mid),
        .bus_rdata(bus_rdata), .bus_rid(bus_rid), .halt_pulse(halt_pulse),
        .exit_code(exit_code), .irq_lines(irq_lines), .cin_valid(cin_valid),
        .cin_data(cin_data), .cin_ready(cin_ready), .cout_valid(cout_valid),
        .cout_data(cout_data), .cout_ready(cout_ready)
    );

    always #5 clk = ~clk;

    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    logic        rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [AW-1:0] a, logic [2:0] len, logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_len   = len;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [AW-1:0] a, logic [MW-1:0] mid, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_addr = a;
        bus_mid  = mid;
        bus_rd   = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R3 read id", 32'(bus_rid), 32'(mid));
    endtask

    always @(posedge clk) rd_seen <= bus_rd;

    // monitor: compare each read response with the queued expectation
    initial begin
        forever begin
            @(negedge clk);
            if (rd_seen) begin
                if (exp_q.size() == 0) begin
                    chk("R6 unexpected response", 32'd1, 32'd0);
                end else begin
                    chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        chk("watchdog expired", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 reset state
        chk("R7 halt", 32'(halt_pulse), 0);
        chk("R7 irq", 32'(irq_lines), 0);
        chk("R7 cout_valid", 32'(cout_valid), 0);
        chk("R7 cin_ready", 32'(cin_ready), 1);
        bus_read(8'h18, 2'd0, 32'h0, "R7 out data");
        bus_read(8'h1A, 2'd0, 32'h1, "R7 out status");
        bus_read(8'h14, 2'd0, 32'h0, "R7 in status");
        bus_read(8'h10, 2'd0, 32'h0, "R7 in data");

        // R3 / R4 / R6 / R1 identity, count, unmapped, alias
        bus_read(8'h04, 2'd2, 32'h2, "R3 cpu index 2");
        bus_read(8'h04, 2'd3, 32'h3, "R3 cpu index 3");
        bus_read(8'h0A, 2'd1, 32'(NC), "R4 count");
        bus_read(8'h2A, 2'd0, 32'(NC), "R1 alias count");
        bus_read(8'h0C, 2'd0, 32'h0, "R6 unmapped 0x0C");
        bus_read(8'h1C, 2'd0, 32'h0, "R6 unmapped 0x1C");
        bus_read(8'h08, 2'd0, 32'h0, "R6 write-only 0x08");
        @(negedge clk);
        chk("R6 rdata held", bus_rdata, 32'h0);

        // R2 exit register
        bus_write(8'h00, 3'd4, 32'h1234_5678);
        chk("R2 halt high", 32'(halt_pulse), 1);
        chk("R2 exit code", 32'(exit_code), 32'h78);
        @(negedge clk);
        chk("R2 halt one cycle", 32'(halt_pulse), 0);
        chk("R2 exit code held", 32'(exit_code), 32'h78);
        bus_write(8'hE0, 3'd1, 32'h0000_009A);
        chk("R1 alias exit halt", 32'(halt_pulse), 1);
        chk("R1 alias exit code", 32'(exit_code), 32'h9A);

        // R5 interrupt lines
        bus_write(8'h08, 3'd2, 32'h0000_0102);
        chk("R5 port 2 level 1", 32'(irq_lines), 32'b100);
        bus_write(8'h08, 3'd2, 32'h0000_0500);
        chk("R5 port 0 level 5", 32'(irq_lines), 32'b101);
        bus_write(8'h08, 3'd1, 32'h0000_FF02);
        chk("R5 one byte gives level 0", 32'(irq_lines), 32'b001);
        bus_write(8'h08, 3'd2, 32'h0000_0103);
        chk("R5 port out of range", 32'(irq_lines), 32'b001);
        bus_write(8'h28, 3'd4, 32'h0000_0101);
        chk("R1 alias irq port 1", 32'(irq_lines), 32'b011);
        repeat (3) @(negedge clk);
        chk("R5 lines hold", 32'(irq_lines), 32'b011);

        // R8 console output
        bus_write(8'h18, 3'd1, 32'h0000_0055);
        chk("R8 cout_valid", 32'(cout_valid), 1);
        chk("R8 cout_data", 32'(cout_data), 32'h55);
        @(negedge clk);
        chk("R8 accepted", 32'(cout_valid), 0);
        bus_read(8'h18, 2'd0, 32'h55, "R8 out readback");
        bus_read(8'h1A, 2'd0, 32'h1, "R8 out status");

        // R9 host not ready
        cout_ready = 1'b0;
        bus_read(8'h1A, 2'd0, 32'h0, "R9 status not ready");
        bus_write(8'h18, 3'd1, 32'h0000_0066);
        chk("R9 ignored no valid", 32'(cout_valid), 0);
        cout_ready = 1'b1;
        bus_read(8'h18, 2'd0, 32'h55, "R9 readback unchanged");
        bus_read(8'h1A, 2'd0, 32'h1, "R9 status ready again");

        // R8 / R9 hold while pending
        bus_write(8'h18, 3'd1, 32'h0000_0077);
        cout_ready = 1'b0;
        @(negedge clk);
        chk("R8 held valid", 32'(cout_valid), 1);
        chk("R8 held data", 32'(cout_data), 32'h77);
        bus_read(8'h1A, 2'd0, 32'h0, "R9 status pending");
        bus_write(8'h18, 3'd1, 32'h0000_0088);
        chk("R9 pending write ignored", 32'(cout_data), 32'h77);
        chk("R9 still valid", 32'(cout_valid), 1);
        cout_ready = 1'b1;
        @(negedge clk);
        chk("R8 drained", 32'(cout_valid), 0);
        bus_read(8'h18, 2'd0, 32'h77, "R9 readback after pending");

        // R10 / R11 console input
        cin_data  = 8'h41;
        cin_valid = 1'b1;
        #1;
        chk("R10 ready when empty", 32'(cin_ready), 1);
        @(negedge clk);
        cin_data = 8'h42;
        chk("R10 ready drops when full", 32'(cin_ready), 0);
        @(negedge clk);
        cin_valid = 1'b0;
        bus_read(8'h14, 2'd0, 32'h1, "R10 status set");
        bus_read(8'h10, 2'd1, 32'h41, "R11 data is first char");
        bus_read(8'h14, 2'd0, 32'h0, "R11 status cleared");
        chk("R10 ready after read", 32'(cin_ready), 1);

        // R12 direct software writes
        bus_write(8'h14, 3'd1, 32'h0000_0007);
        chk("R12 full blocks input", 32'(cin_ready), 0);
        bus_read(8'h14, 2'd0, 32'h7, "R12 in status write");
        bus_write(8'h10, 3'd1, 32'h0000_003C);
        bus_read(8'h10, 2'd0, 32'h3C, "R12 in data write");
        bus_read(8'h14, 2'd0, 32'h0, "R11 cleared after sw data");
        bus_write(8'h1A, 3'd1, 32'h0000_0009);
        bus_read(8'h1A, 2'd0, 32'h9, "R12 out status write");
        bus_write(8'h1A, 3'd1, 32'h0000_0000);
        bus_read(8'h1A, 2'd0, 32'h0, "R12 out status zero");
        bus_write(8'h18, 3'd1, 32'h0000_0099);
        chk("R9 zero status ignores write", 32'(cout_valid), 0);
        bus_read(8'h18, 2'd0, 32'h77, "R9 readback zero status");

        repeat (3) @(negedge clk);
        chk("R6 all responses seen", 32'(exp_q.size()), 0);
        finish_run();
    end

endmodule